// File: doc/BRIEF.md
# Guarded Multi-Bus Move Interconnect

This block executes one instruction word of data transports for a small datapath that the program drives directly. The word carries one move slot for each transport bus. A slot picks a source (a register-file entry, the result port of a function unit, or an immediate carried in the slot), picks a destination (a register-file entry, the operand or trigger port of a function unit, or one of two 1-bit guard registers) and picks a guard condition. Every bus transfers in the same clock edge. A move whose guard is false is dropped.

Computation is a side effect of transport. Writing a unit's trigger port makes that unit combine its stored operand with the trigger value and hold the outcome in its result port. A result can go straight to another unit's port in a later instruction, so it never has to pass through the register file. The register file has fewer read and write ports than there are buses. An instruction that asks for more register-file traffic than the ports allow is flagged, and its register-file writes are discarded.

Top module: `xme_move_engine`

## Requirements
- R1: After reset, all register-file entries, unit operand and result registers and both guard registers are zero, and `illegal_o` is low.
- R2: Bus b uses bits `[b*SLOT_W +: SLOT_W]` of `instr_i` (SLOT_W = 27 by default). Within a slot, bits [1:0] are the guard select, [5:2] the source code, [10:6] the destination code and [26:11] the immediate. All buses read the state held before the instruction and all update it at the same edge.
- R3: Source codes: 0..7 read register-file entry n; 8..11 read the result register of unit n-8; 12 reads the slot immediate; 13..15 deliver zero. A unit result may be moved straight to another unit's port.
- R4: Destination codes: 0..7 write register-file entry n; 8+2k write the operand of unit k; 9+2k write the trigger of unit k; 16 and 17 write guard 0 and guard 1 from data bit 0; 18..31 have no effect.
- R5: A trigger write to unit k loads its result with the prior operand plus the data when k is even, and with the prior operand XOR the data when k is odd. An operand write in the same instruction does not feed that trigger.
- R6: Guard select 00 always moves, 01 moves when guard 0 is 1, 10 moves when guard 1 is 1, and 11 moves when guard 0 is 0. The guards are read as held before the instruction, so a guard written by a move first acts on the next instruction.
- R7: Over all issued slots, whatever their guard, more than 2 slots with a register-file source or more than 1 slot with a register-file destination raise `illegal_o` in the same cycle. All register-file writes of that instruction are then dropped, and its other moves still take effect.
- R8: When several moves that fire name the same destination, the move on the highest-numbered bus decides the written value.
- R9: While `valid_i` is low, no state changes and `illegal_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction word is issued this cycle |
| instr_i | input | NBUS*SLOT_W | Move slots, bus 0 in the low bits |
| illegal_o | output | 1 | Current word exceeds the register-file port budget |
| guard_o | output | 2 | Guard register values |
| fu_res_o | output | NFU*DW | Result registers of the units, unit 0 in the low bits |

## Verification
A single instruction can apply a collision, a guard suppression and a port-budget overflow all at once. The hard cases are a losing higher bus that is guarded off, so the lower bus must win, and an illegal word whose trigger moves must still land while its register-file writes are lost. Directed words set up each such mix deliberately. Thousands of random words then combine the mixes freely, and after each word a bench model built from the requirements predicts the flag, the guards and every unit result. Register-file contents are judged indirectly, by later moves that route entries into unit triggers.

// File: rtl/xme_pkg.sv
package xme_pkg;

   localparam int unsigned GUARD_N = 2;

   typedef enum logic [1:0] {
      GS_ALWAYS = 2'b00,
      GS_G0_SET = 2'b01,
      GS_G1_SET = 2'b10,
      GS_G0_CLR = 2'b11
   } guard_sel_e;

   function automatic logic guard_pass(input logic [1:0] sel, input logic [GUARD_N-1:0] g);
      logic p;
      case (guard_sel_e'(sel))
         GS_ALWAYS: p = 1'b1;
         GS_G0_SET: p = g[0];
         GS_G1_SET: p = g[1];
         GS_G0_CLR: p = ~g[0];
         default:   p = 1'b0;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/xme_slot_decode.sv
module xme_slot_decode #(
   parameter int unsigned DW    = 16,
   parameter int unsigned NREG  = 8,
   parameter int unsigned SRC_W = 4,
   parameter int unsigned DST_W = 5,
   localparam int unsigned SLOT_W = 2 + SRC_W + DST_W + DW
) (
   input  logic [SLOT_W-1:0]           slot_i,
   input  logic                        valid_i,
   input  logic [xme_pkg::GUARD_N-1:0] guard_i,
   output logic                        fire_o,
   output logic                        rd_req_o,
   output logic                        wr_req_o,
   output logic [SRC_W-1:0]            src_o,
   output logic [DST_W-1:0]            dst_o,
   output logic [DW-1:0]               imm_o
);
   localparam int unsigned SRC_LSB = 2;
   localparam int unsigned DST_LSB = SRC_LSB + SRC_W;
   localparam int unsigned IMM_LSB = DST_LSB + DST_W;
   localparam logic [SRC_W-1:0] SRC_RF_LIM = SRC_W'(NREG);
   localparam logic [DST_W-1:0] DST_RF_LIM = DST_W'(NREG);

   logic [1:0] gsel;

   assign gsel  = slot_i[1:0];
   assign src_o = slot_i[SRC_LSB +: SRC_W];
   assign dst_o = slot_i[DST_LSB +: DST_W];
   assign imm_o = slot_i[IMM_LSB +: DW];

   // the budget is a property of the word, so it ignores the guard
   assign rd_req_o = valid_i && (src_o < SRC_RF_LIM);
   assign wr_req_o = valid_i && (dst_o < DST_RF_LIM);
   assign fire_o   = valid_i && xme_pkg::guard_pass(gsel, guard_i);

endmodule

// File: rtl/xme_port_budget.sv
module xme_port_budget #(
   parameter int unsigned NBUS     = 3,
   parameter int unsigned RD_PORTS = 2,
   parameter int unsigned WR_PORTS = 1,
   localparam int unsigned CNT_W   = $clog2(NBUS + 1)
) (
   input  logic [NBUS-1:0] rd_req_i,
   input  logic [NBUS-1:0] wr_req_i,
   output logic            over_o
);
   function automatic logic [CNT_W-1:0] popcnt(input logic [NBUS-1:0] v);
      logic [CNT_W-1:0] n;
      n = '0;
      for (int i = 0; i < int'(NBUS); i++) n = n + CNT_W'(v[i]);
      return n;
   endfunction

   logic rd_over;
   logic wr_over;

   generate
      if (RD_PORTS >= NBUS) begin : g_rd_free
         assign rd_over = 1'b0;
      end else begin : g_rd_limited
         assign rd_over = popcnt(rd_req_i) > CNT_W'(RD_PORTS);
      end
      if (WR_PORTS >= NBUS) begin : g_wr_free
         assign wr_over = 1'b0;
      end else begin : g_wr_limited
         assign wr_over = popcnt(wr_req_i) > CNT_W'(WR_PORTS);
      end
   endgenerate

   assign over_o = rd_over | wr_over;

endmodule

// File: rtl/xme_fu_bank.sv
module xme_fu_bank #(
   parameter int unsigned NFU = 4,
   parameter int unsigned DW  = 16
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [NFU-1:0]          op_we_i,
   input  logic [NFU-1:0][DW-1:0]  op_wd_i,
   input  logic [NFU-1:0]          tr_we_i,
   input  logic [NFU-1:0][DW-1:0]  tr_wd_i,
   output logic [NFU-1:0][DW-1:0]  res_o
);
   for (genvar k = 0; k < int'(NFU); k++) begin : g_unit
      logic [DW-1:0] opnd_q;
      logic [DW-1:0] res_q;
      logic [DW-1:0] res_nxt;

      if ((k % 2) == 0) begin : g_add
         assign res_nxt = opnd_q + tr_wd_i[k];
      end else begin : g_xor
         assign res_nxt = opnd_q ^ tr_wd_i[k];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            opnd_q <= '0;
            res_q  <= '0;
         end else begin
            if (op_we_i[k]) opnd_q <= op_wd_i[k];
            if (tr_we_i[k]) res_q  <= res_nxt;
         end
      end

      assign res_o[k] = res_q;
   end

endmodule

// File: rtl/xme_move_engine.sv
module xme_move_engine #(
   parameter int unsigned NBUS     = 3,
   parameter int unsigned DW       = 16,
   parameter int unsigned NREG     = 8,
   parameter int unsigned NFU      = 4,
   parameter int unsigned RD_PORTS = 2,
   parameter int unsigned WR_PORTS = 1,
   localparam int unsigned SRC_W   = $clog2(NREG + NFU + 1),
   localparam int unsigned DST_W   = $clog2(NREG + 2*NFU + xme_pkg::GUARD_N),
   localparam int unsigned SLOT_W  = 2 + SRC_W + DST_W + DW
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        valid_i,
   input  logic [NBUS*SLOT_W-1:0]      instr_i,
   output logic                        illegal_o,
   output logic [xme_pkg::GUARD_N-1:0] guard_o,
   output logic [NFU*DW-1:0]           fu_res_o
);
   localparam int unsigned GN       = xme_pkg::GUARD_N;
   localparam int unsigned SRC_IMM  = NREG + NFU;
   localparam int unsigned DST_FU0  = NREG;
   localparam int unsigned DST_GRD0 = NREG + 2*NFU;

   generate
      if (NBUS < 1)                      begin : g_bad_nbus  $error("NBUS must be at least 1"); end
      if (RD_PORTS < 1 || WR_PORTS < 1)  begin : g_bad_ports $error("register file needs a read and a write port"); end
      if (NREG < 2 || NFU < 1)           begin : g_bad_size  $error("NREG >= 2 and NFU >= 1 required"); end
      if (DW < 1)                        begin : g_bad_dw    $error("DW must be positive"); end
   endgenerate

   // ---------------------------------------------------------------- state
   logic [NREG-1:0][DW-1:0] rf_q;
   logic [GN-1:0]           guard_q;
   logic [NFU-1:0][DW-1:0]  fu_res;

   // ---------------------------------------------------------------- decode
   logic [NBUS-1:0]              fire;
   logic [NBUS-1:0]              rd_req;
   logic [NBUS-1:0]              wr_req;
   logic [NBUS-1:0][SRC_W-1:0]   src;
   logic [NBUS-1:0][DST_W-1:0]   dst;
   logic [NBUS-1:0][DW-1:0]      imm;
   logic                         over;

   for (genvar b = 0; b < int'(NBUS); b++) begin : g_slot
      xme_slot_decode #(
         .DW    (DW),
         .NREG  (NREG),
         .SRC_W (SRC_W),
         .DST_W (DST_W)
      ) dec_i (
         .slot_i   (instr_i[b*SLOT_W +: SLOT_W]),
         .valid_i  (valid_i),
         .guard_i  (guard_q),
         .fire_o   (fire[b]),
         .rd_req_o (rd_req[b]),
         .wr_req_o (wr_req[b]),
         .src_o    (src[b]),
         .dst_o    (dst[b]),
         .imm_o    (imm[b])
      );
   end

   xme_port_budget #(
      .NBUS     (NBUS),
      .RD_PORTS (RD_PORTS),
      .WR_PORTS (WR_PORTS)
   ) budget_i (
      .rd_req_i (rd_req),
      .wr_req_i (wr_req),
      .over_o   (over)
   );

   // ---------------------------------------------------------------- source side
   logic [NBUS-1:0][DW-1:0] bus_data;

   always_comb begin
      for (int b = 0; b < int'(NBUS); b++) begin
         bus_data[b] = '0;
         for (int r = 0; r < int'(NREG); r++)
            if (src[b] == SRC_W'(r)) bus_data[b] = rf_q[r];
         for (int k = 0; k < int'(NFU); k++)
            if (src[b] == SRC_W'(NREG + k)) bus_data[b] = fu_res[k];
         if (src[b] == SRC_W'(SRC_IMM)) bus_data[b] = imm[b];
      end
   end

   // ---------------------------------------------------------------- destination side
   // ascending bus order: a later (higher) bus overwrites an earlier one
   logic [NREG-1:0]          rf_we;
   logic [NREG-1:0][DW-1:0]  rf_wd;
   logic [NFU-1:0]           op_we;
   logic [NFU-1:0][DW-1:0]   op_wd;
   logic [NFU-1:0]           tr_we;
   logic [NFU-1:0][DW-1:0]   tr_wd;
   logic [GN-1:0]            g_we;
   logic [GN-1:0]            g_wd;

   always_comb begin
      rf_we = '0;
      rf_wd = '0;
      op_we = '0;
      op_wd = '0;
      tr_we = '0;
      tr_wd = '0;
      g_we  = '0;
      g_wd  = '0;
      for (int b = 0; b < int'(NBUS); b++) begin
         if (fire[b]) begin
            for (int r = 0; r < int'(NREG); r++) begin
               if (dst[b] == DST_W'(r)) begin
                  rf_we[r] = 1'b1;
                  rf_wd[r] = bus_data[b];
               end
            end
            for (int k = 0; k < int'(NFU); k++) begin
               if (dst[b] == DST_W'(DST_FU0 + 2*k)) begin
                  op_we[k] = 1'b1;
                  op_wd[k] = bus_data[b];
               end
               if (dst[b] == DST_W'(DST_FU0 + 2*k + 1)) begin
                  tr_we[k] = 1'b1;
                  tr_wd[k] = bus_data[b];
               end
            end
            for (int g = 0; g < int'(GN); g++) begin
               if (dst[b] == DST_W'(DST_GRD0 + g)) begin
                  g_we[g] = 1'b1;
                  g_wd[g] = bus_data[b][0];
               end
            end
         end
      end
   end

   // ---------------------------------------------------------------- storage
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rf_q <= '0;
      end else if (!over) begin
         for (int r = 0; r < int'(NREG); r++)
            if (rf_we[r]) rf_q[r] <= rf_wd[r];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         guard_q <= '0;
      end else begin
         for (int g = 0; g < int'(GN); g++)
            if (g_we[g]) guard_q[g] <= g_wd[g];
      end
   end

   xme_fu_bank #(
      .NFU (NFU),
      .DW  (DW)
   ) fu_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_we_i (op_we),
      .op_wd_i (op_wd),
      .tr_we_i (tr_we),
      .tr_wd_i (tr_wd),
      .res_o   (fu_res)
   );

   assign illegal_o = over;
   assign guard_o   = guard_q;
   assign fu_res_o  = fu_res;

endmodule

// File: rtl/xme_move_checker.sv
module xme_move_checker #(
   parameter int unsigned DW   = 16,
   parameter int unsigned NREG = 8,
   parameter int unsigned NFU  = 4
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic                        valid_i,
   input logic                        illegal_o,
   input logic [xme_pkg::GUARD_N-1:0] guard_o,
   input logic [NFU*DW-1:0]           fu_res_o,
   input logic [NREG*DW-1:0]          rf_flat
);

   // R7: a flagged word leaves the register file untouched
   a_r7_illegal_keeps_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |=> $stable(rf_flat));

   // R9: flag only on an issued word
   a_r9_flag_needs_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> valid_i);

   // R9: idle cycle keeps the register file
   a_r9_idle_keeps_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(rf_flat));

   // R9: idle cycle keeps guards and unit results
   a_r9_idle_keeps_ports: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(guard_o) && $stable(fu_res_o)));

endmodule

bind xme_move_engine xme_move_checker #(
   .DW   (DW),
   .NREG (NREG),
   .NFU  (NFU)
) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .valid_i   (valid_i),
   .illegal_o (illegal_o),
   .guard_o   (guard_o),
   .fu_res_o  (fu_res_o),
   .rf_flat   (rf_q)
);

// File: tb/xme_move_engine_tb_top.sv
module xme_move_engine_tb_top;
   localparam int NBUS = 3;
   localparam int DW = 16;
   localparam int NREG = 8;
   localparam int NFU = 4;
   localparam int SRC_W = 4;
   localparam int DST_W = 5;
   localparam int SLOT_W = 2 + SRC_W + DST_W + DW;
   localparam int IW = NBUS * SLOT_W;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic          rst_n;
   logic          valid;
   logic [IW-1:0] instr;
   logic          illegal;
   logic [1:0]    guard;
   logic [NFU*DW-1:0] fu_res;

   xme_move_engine dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .valid_i   (valid),
      .instr_i   (instr),
      .illegal_o (illegal),
      .guard_o   (guard),
      .fu_res_o  (fu_res)
   );

   int n_chk = 0;
   int n_bad = 0;

   logic [DW-1:0] m_rf [NREG];
   logic [DW-1:0] m_op [NFU];
   logic [DW-1:0] m_res[NFU];
   logic [1:0]    m_g;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [SLOT_W-1:0] mk(input logic [1:0] gs, input int s, input int d, input logic [DW-1:0] im);
      return {im, DST_W'(d), SRC_W'(s), gs};
   endfunction

   function automatic logic gpass(input logic [1:0] gs, input logic [1:0] g);
      case (gs)
         2'b00: return 1'b1;
         2'b01: return g[0];
         2'b10: return g[1];
         default: return ~g[0];
      endcase
   endfunction

   // R7 model: static count over issued slots
   function automatic logic m_illegal(input logic v, input logic [IW-1:0] w);
      int nr, nw;
      nr = 0; nw = 0;
      if (!v) return 1'b0;
      for (int b = 0; b < NBUS; b++) begin
         logic [SLOT_W-1:0] s;
         s = w[b*SLOT_W +: SLOT_W];
         if (int'(s[5:2]) < NREG) nr++;
         if (int'(s[10:6]) < NREG) nw++;
      end
      return (nr > 2) || (nw > 1);
   endfunction

   task automatic m_apply(input logic v, input logic [IW-1:0] w);
      logic [DW-1:0] o_rf[NREG];
      logic [DW-1:0] o_op[NFU];
      logic [DW-1:0] o_res[NFU];
      logic [1:0]    o_g;
      logic          ill;
      o_rf = m_rf; o_op = m_op; o_res = m_res; o_g = m_g;
      ill = m_illegal(v, w);
      if (!v) return;
      for (int b = 0; b < NBUS; b++) begin
         logic [SLOT_W-1:0] s;
         logic [DW-1:0] d;
         int sc, dc;
         s  = w[b*SLOT_W +: SLOT_W];
         sc = int'(s[5:2]);
         dc = int'(s[10:6]);
         if (gpass(s[1:0], o_g)) begin
            if (sc < NREG) d = o_rf[sc];
            else if (sc < NREG + NFU) d = o_res[sc-NREG];
            else if (sc == NREG + NFU) d = s[26:11];
            else d = '0;
            if (dc < NREG) begin
               if (!ill) m_rf[dc] = d;
            end else if (dc < NREG + 2*NFU) begin
               int k;
               k = (dc - NREG) / 2;
               if (((dc - NREG) % 2) == 0) m_op[k] = d;
               else m_res[k] = (k % 2 == 0) ? o_op[k] + d : o_op[k] ^ d;
            end else if (dc < NREG + 2*NFU + 2) begin
               m_g[dc - NREG - 2*NFU] = d[0];
            end
         end
      end
   endtask

   // issue one word starting at a negedge, judge at the next negedge
   task automatic issue(input string tag, input logic v, input logic [IW-1:0] w);
      logic exp_ill;
      valid = v;
      instr = w;
      exp_ill = m_illegal(v, w);
      #1;
      check({tag, " illegal"}, 32'(illegal), 32'(exp_ill));
      m_apply(v, w);
      @(negedge clk);
      check({tag, " guard"}, 32'(guard), 32'(m_g));
      for (int k = 0; k < NFU; k++)
         check({tag, " result"}, 32'(fu_res[k*DW +: DW]), 32'(m_res[k]));
      valid = 1'b0;
   endtask

   function automatic logic [IW-1:0] w3(input logic [SLOT_W-1:0] a, input logic [SLOT_W-1:0] b, input logic [SLOT_W-1:0] c);
      return {c, b, a};
   endfunction

   localparam logic [SLOT_W-1:0] NOP = {16'h0, 5'd31, 4'd15, 2'b00};

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < NREG; i++) m_rf[i] = '0;
      for (int i = 0; i < NFU; i++) begin m_op[i] = '0; m_res[i] = '0; end
      m_g = '0;
      rst_n = 1'b0; valid = 1'b0; instr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 guard", 32'(guard), 32'h0);
      check("R1 results", 32'(fu_res[31:0]), 32'h0);
      check("R1 results hi", 32'(fu_res[63:32]), 32'h0);
      check("R1 illegal", 32'(illegal), 32'h0);

      // R2 R3 R4: immediate to entry 3, then entry 3 to trigger of unit 0
      issue("R4 imm to rf", 1'b1, w3(mk(2'b00, 12, 3, 16'h1234), NOP, NOP));
      issue("R3 rf to trigger", 1'b1, w3(NOP, mk(2'b00, 3, 9, 16'h0), NOP));
      check("R3 literal", 32'(fu_res[15:0]), 32'h1234);

      // R5: operand and trigger in one word, trigger sees old operand
      issue("R5 same word", 1'b1, w3(mk(2'b00, 12, 8, 16'd5), mk(2'b00, 12, 9, 16'd7), NOP));
      check("R5 literal old operand", 32'(fu_res[15:0]), 32'd7);
      issue("R5 new operand", 1'b1, w3(NOP, NOP, mk(2'b00, 12, 9, 16'd1)));
      check("R5 literal add", 32'(fu_res[15:0]), 32'd6);

      // R8: two buses hit trigger of unit 1, bus 2 wins (xor with operand 0)
      issue("R8 collision", 1'b1, w3(mk(2'b00, 12, 11, 16'hAAAA), NOP, mk(2'b00, 12, 11, 16'h0F0F)));
      check("R8 literal", 32'(fu_res[31:16]), 32'h0F0F);
      // R8 with the higher bus guarded off: lower bus wins
      issue("R8 guarded loser", 1'b1, w3(mk(2'b00, 12, 11, 16'h00FF), NOP, mk(2'b01, 12, 11, 16'hFFFF)));
      check("R8 literal lower", 32'(fu_res[31:16]), 32'h00FF);

      // R6: guard write plus guarded move in one word; the move sees the old guard
      issue("R6 same word", 1'b1, w3(mk(2'b00, 12, 16, 16'd1), mk(2'b01, 12, 9, 16'd9), NOP));
      check("R6 literal suppressed", 32'(fu_res[15:0]), 32'd6);
      issue("R6 next word", 1'b1, w3(mk(2'b01, 12, 9, 16'd9), mk(2'b11, 12, 13, 16'd3), mk(2'b10, 12, 15, 16'd4)));
      check("R6 literal taken", 32'(fu_res[15:0]), 32'd14);

      // R7: two register-file writes flagged, trigger still lands
      issue("R7 write overflow", 1'b1, w3(mk(2'b00, 12, 0, 16'h1111), mk(2'b00, 12, 1, 16'h2222), mk(2'b00, 12, 15, 16'h0003)));
      issue("R7 rf0 unchanged", 1'b1, w3(mk(2'b00, 0, 13, 16'h0), NOP, NOP));
      check("R7 literal rf0", 32'(fu_res[47:32]), 32'h0);
      // R7: three reads flagged even when guarded off
      issue("R7 read overflow", 1'b1, w3(mk(2'b10, 3, 8, 16'h0), mk(2'b10, 3, 8, 16'h0), mk(2'b00, 3, 5, 16'h0)));

      // R3: unit result straight into another unit trigger
      issue("R3 bypass", 1'b1, w3(mk(2'b00, 8, 13, 16'h0), NOP, NOP));
      // R4: null destination and zero source codes
      issue("R4 null dst", 1'b1, w3(mk(2'b00, 12, 20, 16'hBEEF), mk(2'b00, 14, 9, 16'h7777), NOP));

      // R9: idle cycle with a busy word on the pins
      issue("R9 idle", 1'b0, w3(mk(2'b00, 12, 16, 16'h0), mk(2'b00, 12, 9, 16'h5), mk(2'b00, 12, 2, 16'h5)));
      issue("R9 rf2 unchanged", 1'b1, w3(mk(2'b00, 2, 9, 16'h0), NOP, NOP));

      // R2 random words
      for (int n = 0; n < 4000; n++) begin
         logic [IW-1:0] w;
         logic v;
         for (int b = 0; b < NBUS; b++) begin
            int s, d;
            s = ($urandom % 3 == 0) ? int'($urandom % 8) : int'(8 + $urandom % 8);
            d = ($urandom % 3 == 0) ? int'($urandom % 8) : int'(8 + $urandom % 24);
            w[b*SLOT_W +: SLOT_W] = mk(2'($urandom), s, d, DW'($urandom));
         end
         v = ($urandom % 8) != 0;
         issue("R2 random", v, w);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule